// File: doc/BRIEF.md
# I2C Target with Byte-Count Reporting

This block is a 7-bit-address I2C target. It watches the open-drain SDA and SCL lines with the system clock and answers only the address held in its own-address register. When a controller writes to it, the data bytes land one after another in a receive store. When a controller reads from it, bytes are shifted out in order from a transmit store. A local host loads the transmit store, reads the receive store and can change the own address, all through plain indexed ports.

Three bus events close an open transfer: a STOP, a repeated START, or SCL held low for longer than a timeout window of about 34 ms. For a write, the number of bytes received is then copied into a single length register that both directions share. For a read, the number of bytes fully shifted out is copied there instead. A one-cycle completion strobe is raised in the same cycle. The host uses the strobe and the length to collect a message or to refill the transmit store.

Top module: `i2ct_target`

## Requirements
- R1: After reset the own address is 0x0A, `len` is 0, `done` is low and `sda_oe` is low.
- R2: The first byte after a START carries the address in bits 7..1 and the direction in bit 0 (0 = controller writes, 1 = controller reads). A matching address is ACKed. A mismatch is NACKed, and every byte that follows up to the next START is ignored: no ACK, no change to `len`, `done` or the receive store.
- R3: In a write transfer each data byte is ACKed and stored at receive positions 0, 1, 2 and so on, in order.
- R4: In a read transfer, bytes from transmit positions 0, 1, 2 and so on are sent MSB first. Sending continues while the controller ACKs and stops after a NACK.
- R5: Written bytes beyond position DEPTH-1 are ACKed and dropped. Read bytes beyond position DEPTH-1 are 0xFF.
- R6: A STOP ends an addressed transfer. `len` takes the byte count (bytes received for a write, bytes fully sent for a read, 0 when there were no data bytes) and `done` pulses high for exactly one cycle.
- R7: A repeated START ends the open transfer in the same way as R6 and starts a new address phase.
- R8: SCL held low for TMO_CYC clocks ends the open transfer in the same way as R6 and releases SDA.
- R9: A pulse on `addr_we` loads `addr_wd` as the new own address. The old address is no longer answered.
- R10: `sda_oe` changes only just after a synchronised SCL falling edge or on a bus event that ends a transfer. It is low whenever `done` is high.
- R11: `len` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_we | input | 1 | Load a new own address |
| addr_wd | input | 7 | Own address value to load |
| tx_we | input | 1 | Host write strobe for the transmit store |
| tx_widx | input | IDX_W | Transmit store position to write |
| tx_wdata | input | 8 | Transmit byte |
| rx_ridx | input | IDX_W | Receive store position to read |
| rx_rdata | output | 8 | Receive store byte at `rx_ridx` |
| len | output | 8 | Byte count of the last completed transfer |
| done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
Two cases are the hardest to reach from the pins. In the first, a transfer is ended by a repeated START rather than a STOP, so the length from the first half must be checked while the bus is still busy with the second address. In the second, SCL is left low until the timeout fires in the middle of a write. The bench reaches both with its bit-level controller tasks: it chains a write directly into a read without a STOP, and it parks SCL low for longer than a shortened timeout before it releases the bus. Overflow past the end of both stores, with 18-byte bursts, and a controller that keeps clocking data after a NACKed address are driven from the vector table.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACKP,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TX_REL,
        ST_TX_MACK,
        ST_TX_NEXT,
        ST_WAIT
    } seq_st_e;

    typedef struct packed {
        seq_st_e     st;
        logic [3:0]  bits;
        logic [7:0]  sh;
        logic        rw;
        logic        act;
        logic        drv;
        logic [7:0]  cnt;
        logic [7:0]  len;
        logic        done;
        logic [6:0]  own;
    } seq_s;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign q    = chain_q[STAGES-1];
    assign rise = q & ~prev_q;
    assign fall = ~q & prev_q;
endmodule

// File: rtl/i2ct_tmo.sv
module i2ct_tmo #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (scl)                   cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
    end

    assign hit = ~scl && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/i2ct_buf.sv
module i2ct_buf #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] widx,
    input  logic [7:0] wdata,
    input  logic [7:0] ridx,
    output logic [7:0] rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we && (widx < 8'(DEPTH))) begin
            mem_q[widx[IW-1:0]] <= wdata;
        end
    end

    assign rdata = (ridx < 8'(DEPTH)) ? mem_q[ridx[IW-1:0]] : 8'hFF;
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int         DEPTH       = 16,
    parameter int         TMO_CYC     = 4_250_000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] RESET_ADDR  = 7'h0A,
    localparam int        IDX_W       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_we,
    input  logic [6:0]       addr_wd,
    input  logic             tx_we,
    input  logic [IDX_W-1:0] tx_widx,
    input  logic [7:0]       tx_wdata,
    input  logic [IDX_W-1:0] rx_ridx,
    output logic [7:0]       rx_rdata,
    output logic [7:0]       len,
    output logic             done
);
    // line synchronisers: index 0 = SCL, index 1 = SDA
    logic [1:0] raw, lvl, up, dn;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[g]),
            .q(lvl[g]), .rise(up[g]), .fall(dn[g])
        );
    end

    logic scl_s, sda_s, scl_rise, scl_fall;
    logic start_c, stop_c, tmo_hit, bus_evt;
    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = up[0];
    assign scl_fall = dn[0];
    assign start_c  = scl_s & ~scl_rise & dn[1];
    assign stop_c   = scl_s & ~scl_rise & up[1];

    i2ct_tmo #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .hit(tmo_hit)
    );
    assign bus_evt = start_c | stop_c | tmo_hit;

    seq_s       q, d;
    logic       rx_we;
    logic [7:0] rx_byte, tx_byte;

    i2ct_buf #(.DEPTH(DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .we(rx_we), .widx(q.cnt), .wdata(rx_byte),
        .ridx(8'(rx_ridx)), .rdata(rx_rdata)
    );

    i2ct_buf #(.DEPTH(DEPTH)) u_txbuf (
        .clk(clk), .rst_n(rst_n), .we(tx_we), .widx(8'(tx_widx)), .wdata(tx_wdata),
        .ridx(q.cnt), .rdata(tx_byte)
    );

    assign rx_byte = {q.sh[6:0], sda_s};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rx_we  = 1'b0;
        if (addr_we) d.own = addr_wd;

        if (bus_evt) begin
            if (q.act) begin
                d.len  = q.cnt;
                d.done = 1'b1;
            end
            d.act  = 1'b0;
            d.drv  = 1'b0;
            d.bits = '0;
            d.st   = start_c ? ST_ADDR : ST_IDLE;
        end else begin
            unique case (q.st)
                ST_ADDR: if (scl_rise) begin
                    d.sh   = {q.sh[6:0], sda_s};
                    d.bits = q.bits + 1'b1;
                    if (q.bits == 4'd7) begin
                        if (q.sh[6:0] == q.own) begin
                            d.st  = ST_ACKP;
                            d.rw  = sda_s;
                            d.act = 1'b1;
                            d.cnt = '0;
                        end else begin
                            d.st  = ST_IDLE;
                        end
                    end
                end
                ST_ACKP: if (scl_fall) begin
                    d.drv = 1'b1;
                    d.st  = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    d.bits = '0;
                    if (q.rw) begin
                        d.sh  = tx_byte;
                        d.drv = ~tx_byte[7];
                        d.st  = ST_TX;
                    end else begin
                        d.drv = 1'b0;
                        d.st  = ST_RX;
                    end
                end
                ST_RX: if (scl_rise) begin
                    d.sh   = rx_byte;
                    d.bits = q.bits + 1'b1;
                    if (q.bits == 4'd7) begin
                        rx_we = 1'b1;
                        d.cnt = (q.cnt == 8'hFF) ? q.cnt : q.cnt + 1'b1;
                        d.st  = ST_ACKP;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 1'b1;
                        if (q.bits == 4'd7) begin
                            d.cnt = (q.cnt == 8'hFF) ? q.cnt : q.cnt + 1'b1;
                            d.st  = ST_TX_REL;
                        end
                    end else if (scl_fall) begin
                        d.sh  = {q.sh[6:0], 1'b1};
                        d.drv = ~q.sh[6];
                    end
                end
                ST_TX_REL: if (scl_fall) begin
                    d.drv = 1'b0;
                    d.st  = ST_TX_MACK;
                end
                ST_TX_MACK: if (scl_rise) begin
                    d.st = sda_s ? ST_WAIT : ST_TX_NEXT;
                end
                ST_TX_NEXT: if (scl_fall) begin
                    d.sh   = tx_byte;
                    d.drv  = ~tx_byte[7];
                    d.bits = '0;
                    d.st   = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.own  <= RESET_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.drv;
    assign len    = q.len;
    assign done   = q.done;
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       bus_evt,
    input logic       sda_oe,
    input logic       done,
    input logic [7:0] len
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R10
    release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || bus_evt));

    // R10
    release_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sda_oe);

    // R11
    len_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(len) |-> done);
endmodule

bind i2ct_target i2ct_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bus_evt(bus_evt),
    .sda_oe(sda_oe), .done(done), .len(len)
);

// File: tb/sim_i2ct_target.sv
module sim_i2ct_target;
    localparam int DEPTH = 16;
    localparam int IW    = 4;
    localparam int TMO   = 600;
    localparam int T     = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1, sda_m = 1'b1;
    logic          sda_oe, sda_line;
    logic          addr_we = 1'b0;
    logic [6:0]    addr_wd = '0;
    logic          tx_we = 1'b0;
    logic [IW-1:0] tx_widx = '0, rx_ridx = '0;
    logic [7:0]    tx_wdata = '0, rx_rdata, len;
    logic          done;

    assign sda_line = sda_m & ~sda_oe;

    i2ct_target #(.DEPTH(DEPTH), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_we(addr_we), .addr_wd(addr_wd), .tx_we(tx_we), .tx_widx(tx_widx),
        .tx_wdata(tx_wdata), .rx_ridx(rx_ridx), .rx_rdata(rx_rdata),
        .len(len), .done(done)
    );

    int nchk = 0, nbad = 0, done_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] rx_model [DEPTH];

    always @(posedge clk) if (rst_n && done) done_cnt++;

    // entry: {rw, addr[6:0], count[7:0], pattern base[7:0]}
    localparam logic [23:0] VEC [6] = '{
        {1'b0, 7'h0A, 8'd3,  8'h11},
        {1'b0, 7'h0B, 8'd2,  8'h22},
        {1'b1, 7'h0A, 8'd4,  8'h00},
        {1'b0, 7'h0A, 8'd18, 8'h40},
        {1'b1, 7'h0A, 8'd18, 8'h00},
        {1'b1, 7'h0C, 8'd1,  8'h00}
    };

    function automatic logic [7:0] txp(int i);
        return 8'(i * 7 + 33);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b0; tick(T);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b1; tick(T);
    endtask

    task automatic wbit(logic b);
        sda_m = b;    tick(T);
        scl_m = 1'b1; tick(T);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        b = sda_line;
        scl_m = 1'b0; tick(T);
    endtask

    task automatic wbyte(logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(~ack);
    endtask

    task automatic xfer(logic rw, logic [6:0] a, int n, logic [7:0] base, bit match);
        logic ak;
        logic [7:0] v, e;
        i2c_start();
        wbyte({a, rw}, ak);
        check(ak == match, "R2 address ack", ak, match);
        if (!rw) begin
            for (int i = 0; i < n; i++) begin
                wbyte(8'(base + i * 5), ak);
                check(ak == match, (i < DEPTH) ? "R3 data ack" : "R5 ack beyond end", ak, match);
                if (match && i < DEPTH) rx_model[i] = 8'(base + i * 5);
            end
        end else if (match) begin
            for (int i = 0; i < n; i++) begin
                rbyte(v, i != n - 1);
                e = (i < DEPTH) ? txp(i) : 8'hFF;
                check(v == e, (i < DEPTH) ? "R4 read data" : "R5 read beyond end", v, e);
            end
        end
    endtask

    task automatic rx_compare(string what);
        for (int i = 0; i < DEPTH; i++) begin
            rx_ridx = IW'(i);
            tick(1);
            check(rx_rdata == rx_model[i], what, rx_rdata, rx_model[i]);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int d0;
        logic [7:0] l0;
        for (int i = 0; i < DEPTH; i++) rx_model[i] = 8'h00;
        tick(5);
        // R1 reset state
        check(len == 8'h00, "R1 len after reset", len, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);

        for (int i = 0; i < DEPTH; i++) begin
            tx_we = 1'b1; tx_widx = IW'(i); tx_wdata = txp(i); tick(1);
        end
        tx_we = 1'b0;

        for (int k = 0; k < 6; k++) begin
            logic rw; logic [6:0] a; int n; bit m;
            rw = VEC[k][23]; a = VEC[k][22:16]; n = int'(VEC[k][15:8]);
            m  = (a == 7'h0A);   // R1: reset own address answered
            l0 = len; d0 = done_cnt;
            xfer(rw, a, n, VEC[k][7:0], m);
            i2c_stop();
            tick(4);
            if (m) begin
                check(len == 8'(n), "R6 len after stop", len, n);
                check(done_cnt == d0 + 1, "R6 one done pulse", done_cnt - d0, 1);
                if (!rw) rx_compare("R3 rx store contents");
            end else begin
                check(len == l0, "R2 R11 len kept on mismatch", len, l0);
                check(done_cnt == d0, "R2 no done on mismatch", done_cnt - d0, 0);
                if (!rw) rx_compare("R2 rx store untouched");
            end
            check(sda_oe == 1'b0, "R10 sda released after stop", sda_oe, 0);
        end

        // R6 zero-length write
        d0 = done_cnt;
        xfer(1'b0, 7'h0A, 0, 8'h00, 1'b1);
        i2c_stop(); tick(4);
        check(len == 8'h00, "R6 zero-length len", len, 0);
        check(done_cnt == d0 + 1, "R6 zero-length done", done_cnt - d0, 1);

        // R7 repeated START between a write and a read
        d0 = done_cnt;
        xfer(1'b0, 7'h0A, 2, 8'h50, 1'b1);
        xfer(1'b1, 7'h0A, 1, 8'h00, 1'b1);
        check(len == 8'd2, "R7 len at repeated start", len, 2);
        check(done_cnt == d0 + 1, "R7 done at repeated start", done_cnt - d0, 1);
        i2c_stop(); tick(4);
        check(len == 8'd1, "R7 len of read after restart", len, 1);
        check(done_cnt == d0 + 2, "R7 second done", done_cnt - d0, 2);

        // R8 SCL low timeout in the middle of a write
        d0 = done_cnt;
        xfer(1'b0, 7'h0A, 3, 8'h60, 1'b1);
        tick(TMO + 50);
        check(len == 8'd3, "R8 len on timeout", len, 3);
        check(done_cnt == d0 + 1, "R8 done on timeout", done_cnt - d0, 1);
        check(sda_oe == 1'b0, "R8 sda released on timeout", sda_oe, 0);
        i2c_stop(); tick(4);
        check(done_cnt == d0 + 1, "R8 no extra done after stop", done_cnt - d0, 1);

        // R9 own address change
        addr_wd = 7'h33; addr_we = 1'b1; tick(1); addr_we = 1'b0;
        d0 = done_cnt;
        xfer(1'b0, 7'h0A, 1, 8'h77, 1'b0);
        i2c_stop(); tick(4);
        check(done_cnt == d0, "R9 old address ignored", done_cnt - d0, 0);
        xfer(1'b0, 7'h33, 1, 8'h7A, 1'b1);
        i2c_stop(); tick(4);
        check(len == 8'd1, "R9 new address len", len, 1);
        check(done_cnt == d0 + 1, "R9 new address done", done_cnt - d0, 1);
        rx_compare("R9 R3 rx store after new address");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule